// File: doc/BRIEF.md
# Command Slot Status Register

This block holds the read-only status word for one storage port. It keeps an active flag for each of 31 command slots. The command-fetch logic raises a load pulse with a slot index when it writes a command into slot memory, and that pulse sets the slot's flag. A per-slot completion pulse clears the flag. The most significant bit of the word is a summary attention flag. It is the OR of the port's interrupt status conditions after they are masked by the interrupt enable vector.

A single-cycle read strobe stands in for the host bus. The block returns a registered snapshot of the word one cycle after the strobe. One cycle after that, it issues a pulse that clears the port's latched command-completion indication. A control input suppresses that pulse when set. The slot memory, the command engine and the bus bridge are outside the block.

Top module: `slot_status_reg`

## Requirements
- R1: After reset all slot flags are 0, the read-valid and completion-clear outputs are 0, and the read data register is 0.
- R2: A load pulse with a slot index below the slot count sets that slot's flag on the next clock edge. Bit i of the word is the flag of slot i.
- R3: A completion pulse on bit i of the completion vector clears slot i's flag on the next clock edge. Flags of other slots are unaffected.
- R4: If a load for slot i and a completion for slot i arrive in the same cycle, the flag of slot i is 1 afterwards.
- R5: The attention output is combinational. It equals the OR of the interrupt status vector ANDed with the interrupt mask vector, so it is 0 whenever the mask is all zeros.
- R6: A read strobe in cycle t gives read-valid high in cycle t+1. The read data then holds the attention flag in bit 31 and the slot flags in bits 30..0, all as they were in cycle t. Without a strobe, read-valid is low.
- R7: A read strobe in cycle t with the no-clear-on-read input at 0 gives a one-cycle completion-clear pulse in cycle t+2. Each strobe gives one pulse.
- R8: A read strobe taken while no-clear-on-read is 1 gives no completion-clear pulse.
- R9: A load pulse whose index is the slot count or higher (index 31 with the 5-bit index) changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Command written into slot memory |
| loadIdx | input | 5 | Slot index of the load |
| slotDone | input | 31 | Per-slot completion pulses |
| intStatus | input | 16 | Port interrupt status conditions |
| intMask | input | 16 | Interrupt enable mask |
| noClearOnRead | input | 1 | Suppresses the read side effect when 1 |
| rdStrobe | input | 1 | Register read request |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Attention in bit 31, slot flags in bits 30..0 |
| slotActive | output | 31 | Live slot flags |
| attention | output | 1 | Live masked-interrupt summary |
| cmplClear | output | 1 | Clear pulse for latched completion status |

## Verification
The assertions check on every cycle the per-slot set, clear and set-wins rules, that an out-of-range index is ignored, the one-cycle read latency, and the placement or absence of the clear pulse two cycles after a strobe. Only the bench's scenarios can show the actual content of a returned word: flags built up over a sequence of loads and completions, the attention bit captured under different mask patterns, and back-to-back reads, each with its own clear pulse.

// File: rtl/slot_status_pkg.sv
package slot_status_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic capture;   // snapshot the status word into the read register
  } ctrlStrobes_t;
endpackage

// File: rtl/slot_status_ctrl.sv
module slot_status_ctrl
  import slot_status_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rdStrobe,
  input  logic         noClearOnRead,
  output ctrlStrobes_t strobes,
  output logic         rdValid,
  output logic         cmplClear
);
  logic clrArmed;

  assign strobes.capture = rdStrobe;

  // Stage 1: data returned; stage 2: side effect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      clrArmed  <= 1'b0;
      cmplClear <= 1'b0;
    end else begin
      rdValid   <= rdStrobe;
      clrArmed  <= rdStrobe & ~noClearOnRead;
      cmplClear <= clrArmed;
    end
  end
endmodule

// File: rtl/slot_status_datapath.sv
module slot_status_datapath
  import slot_status_pkg::*;
#(
  parameter int NUM_SLOTS = 31,
  parameter int INT_W     = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS + 1),
  localparam int DATA_W   = NUM_SLOTS + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic                 loadValid,
  input  logic [IDX_W-1:0]     loadIdx,
  input  logic [NUM_SLOTS-1:0] slotDone,
  input  logic [INT_W-1:0]     intStatus,
  input  logic [INT_W-1:0]     intMask,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_SLOTS-1:0] slotActive,
  output logic                 attention
);
  logic [NUM_SLOTS-1:0] setVec;
  logic [NUM_SLOTS-1:0] flagsNext;

  // One-hot decode of the load index; out-of-range indices hit no bit
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gDecode
    assign setVec[i] = loadValid && (loadIdx == IDX_W'(i));
  end

  // Set has priority over a same-cycle completion
  assign flagsNext = (slotActive & ~slotDone) | setVec;

  always_ff @(posedge clk) begin
    if (!rstN) slotActive <= '0;
    else       slotActive <= flagsNext;
  end

  assign attention = |(intStatus & intMask);

  always_ff @(posedge clk) begin
    if (!rstN)                rdData <= '0;
    else if (strobes.capture) rdData <= {attention, slotActive};
  end
endmodule

// File: rtl/slot_status_reg.sv
module slot_status_reg
  import slot_status_pkg::*;
#(
  parameter int NUM_SLOTS = 31,
  parameter int INT_W     = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS + 1),
  localparam int DATA_W   = NUM_SLOTS + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadValid,
  input  logic [IDX_W-1:0]     loadIdx,
  input  logic [NUM_SLOTS-1:0] slotDone,
  input  logic [INT_W-1:0]     intStatus,
  input  logic [INT_W-1:0]     intMask,
  input  logic                 noClearOnRead,
  input  logic                 rdStrobe,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_SLOTS-1:0] slotActive,
  output logic                 attention,
  output logic                 cmplClear
);
  ctrlStrobes_t strobes;

  slot_status_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rdStrobe     (rdStrobe),
    .noClearOnRead(noClearOnRead),
    .strobes      (strobes),
    .rdValid      (rdValid),
    .cmplClear    (cmplClear)
  );

  slot_status_datapath #(.NUM_SLOTS(NUM_SLOTS), .INT_W(INT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadValid (loadValid),
    .loadIdx   (loadIdx),
    .slotDone  (slotDone),
    .intStatus (intStatus),
    .intMask   (intMask),
    .rdData    (rdData),
    .slotActive(slotActive),
    .attention (attention)
  );
endmodule

// File: rtl/slot_status_checker.sv
module slot_status_checker #(
  parameter int NUM_SLOTS = 31,
  parameter int INT_W     = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS + 1),
  localparam int DATA_W   = NUM_SLOTS + 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 loadValid,
  input logic [IDX_W-1:0]     loadIdx,
  input logic [NUM_SLOTS-1:0] slotDone,
  input logic [INT_W-1:0]     intStatus,
  input logic [INT_W-1:0]     intMask,
  input logic                 noClearOnRead,
  input logic                 rdStrobe,
  input logic                 rdValid,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_SLOTS-1:0] slotActive,
  input logic                 attention,
  input logic                 cmplClear
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    assert_load_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
      (loadValid && loadIdx == IDX_W'(i)) |=> slotActive[i]);
    assert_done_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
      (slotDone[i] && !(loadValid && loadIdx == IDX_W'(i))) |=> !slotActive[i]);
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
      (slotDone[i] && loadValid && loadIdx == IDX_W'(i)) |=> slotActive[i]);
  end

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    (intMask == '0) |-> !attention);

  assert_read_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> rdValid);
  assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> !rdValid);

  assert_clear_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !noClearOnRead) |-> ##2 cmplClear);
  assert_clear_suppressed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && noClearOnRead) |-> ##2 !cmplClear);

  assert_out_of_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && loadIdx >= IDX_W'(NUM_SLOTS) && slotDone == '0) |=> $stable(slotActive));
endmodule

bind slot_status_reg slot_status_checker #(.NUM_SLOTS(NUM_SLOTS), .INT_W(INT_W)) u_chk (.*);

// File: tb/slot_status_reg_bench.sv
module slot_status_reg_bench;
  localparam int NS = 31;
  localparam int IW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          loadValid;
  logic [4:0]    loadIdx;
  logic [NS-1:0] slotDone;
  logic [IW-1:0] intStatus, intMask;
  logic          noClearOnRead, rdStrobe;
  logic          rdValid, attention, cmplClear;
  logic [31:0]   rdData;
  logic [NS-1:0] slotActive;

  typedef struct {
    logic [31:0] data;
    logic        clr;
    string       tag;
  } item_t;

  item_t         expQ[$];
  logic [NS-1:0] model = '0;
  int            tests = 0;
  int            fails = 0;
  logic          clrExpect = 1'b0;
  logic          hadRead = 1'b0;
  bit            monOn = 1'b0;

  always #4 clk = ~clk;

  slot_status_reg u_slot_status_reg (.*);

  // Drive one cycle of stimulus; model the result of the following edge
  task automatic step(input logic lv, input logic [4:0] idx, input logic [NS-1:0] done,
                      input logic rd, input logic ncr, input string tag);
    item_t it;
    @(posedge clk); #1;
    loadValid = lv; loadIdx = idx; slotDone = done;
    rdStrobe = rd; noClearOnRead = ncr;
    if (rd) begin
      it.data = {|(intStatus & intMask), model};
      it.clr  = ~ncr;
      it.tag  = tag;
      expQ.push_back(it);
    end
    model = (model & ~done) | ((lv && idx < 5'(NS)) ? (NS'(1) << idx) : '0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 5'd0, '0, 1'b0, 1'b0, "");
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected reads and tracks the clear pulse
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (cmplClear !== clrExpect) begin
          tests++; fails++;
          $display("FAIL R7/R8 cmplClear actual=%b expected=%b", cmplClear, clrExpect);
        end else if (hadRead) tests++;
        clrExpect = 1'b0; hadRead = 1'b0;
        if (rdValid) begin
          if (expQ.size() == 0) begin
            tests++; fails++;
            $display("FAIL R6 unexpected rdValid actual=1 expected=0");
          end else begin
            it = expQ.pop_front();
            chk(rdData === it.data, it.tag, rdData, it.data);
            clrExpect = it.clr; hadRead = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; loadValid = 1'b0; loadIdx = '0; slotDone = '0;
    intStatus = '0; intMask = '0; noClearOnRead = 1'b0; rdStrobe = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(slotActive === '0, "R1 slotActive", 32'(slotActive), 0);
    chk(rdValid === 1'b0 && cmplClear === 1'b0, "R1 rdValid/cmplClear",
        {30'd0, rdValid, cmplClear}, 0);
    chk(rdData === '0, "R1 rdData", rdData, 0);
    monOn = 1'b1;

    // R2 loads, including the top slot
    step(1'b1, 5'd0, '0, 1'b0, 1'b0, "");
    step(1'b1, 5'd5, '0, 1'b0, 1'b0, "");
    step(1'b1, 5'd30, '0, 1'b0, 1'b0, "");
    step(1'b0, 5'd0, '0, 1'b1, 1'b0, "R2 R7 read after loads");
    idle(3);

    // R3 completion of slot 5; R8 read with clear suppressed
    step(1'b0, 5'd0, NS'(1) << 5, 1'b0, 1'b0, "");
    step(1'b0, 5'd0, '0, 1'b1, 1'b1, "R3 R8 read after completion");
    idle(3);

    // R4 same-cycle set and clear of slot 7, then of an active slot 0
    step(1'b1, 5'd7, NS'(1) << 7, 1'b0, 1'b0, "");
    step(1'b1, 5'd0, NS'(1), 1'b0, 1'b0, "");
    step(1'b0, 5'd0, '0, 1'b1, 1'b0, "R4 set wins");
    idle(3);

    // R9 out-of-range index
    step(1'b1, 5'd31, '0, 1'b0, 1'b0, "");
    step(1'b0, 5'd0, '0, 1'b1, 1'b0, "R9 index 31 ignored");
    idle(3);

    // R5 attention is combinational and captured in bit 31
    @(posedge clk); #1;
    intStatus = 16'h0010; intMask = 16'h0000; #1;
    chk(attention === 1'b0, "R5 unmasked-off", 32'(attention), 0);
    intMask = 16'h00F0; #1;
    chk(attention === 1'b1, "R5 masked-on", 32'(attention), 1);
    intStatus = 16'h8000; #1;
    chk(attention === 1'b0, "R5 falls when condition removed", 32'(attention), 0);
    intStatus = 16'h0020;
    step(1'b0, 5'd0, '0, 1'b1, 1'b0, "R5 R6 read with attention");
    idle(3);
    intStatus = '0;

    // R6/R7 back-to-back reads with changing flags and mixed suppression
    step(1'b1, 5'd12, '0, 1'b1, 1'b0, "R6 back-to-back 1");
    step(1'b0, 5'd0, (NS'(1) << 30) | (NS'(1) << 12), 1'b1, 1'b1, "R6 back-to-back 2");
    step(1'b1, 5'd3, '0, 1'b1, 1'b0, "R6 back-to-back 3");
    step(1'b0, 5'd0, '0, 1'b1, 1'b0, "R6 back-to-back 4");
    idle(4);

    @(negedge clk);
    chk(slotActive === model, "R2 R3 live flags", 32'(slotActive), 32'(model));
    chk(expQ.size() == 0, "R6 all reads returned", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule